// File: doc/BRIEF.md
# Card clock divider with bypass

This block derives the clock sent to a memory card from a master clock. A control word, loaded through a single write strobe, carries the divide value, two bus-width flags, a double-data-rate enable, a hardware flow-control enable, a high-speed bus flag and a clock-source select. For a non-zero divide value N, the card clock runs at the master frequency divided by 2N. It is high for N master cycles and low for N master cycles.

A divide value of zero passes the master clock straight to the output in single-rate mode. Double-data-rate mode cannot use that bypass, so a zero there is treated as one. A companion one-cycle strobe tells the command and data logic when a card-clock edge has just occurred. In single-rate mode it marks rising edges only. In double-data-rate mode it marks both edges. A new divide value is only switched in after a completed low half, so the output never shows a shortened pulse.

After reset the divide field holds its largest value. The card clock therefore starts at its slowest rate rather than stopped. The remaining control fields are echoed as decoded status.

Top module: `card_clk_div`

## Requirements
- R1: After reset card_clk and ck_en are low, bus_w is 0, and ddr_on, hwfc_on, hs_on and fbck_sel are 0. The divide field resets to its largest value (2^DIV_W - 1), so the card clock runs at its slowest rate.
- R2: The divide value sits in cfg_wdata[DIV_W-1:0]. With a non-zero value N, card_clk stays high for N master cycles and low for N master cycles.
- R3: With a divide value of 0 and cfg_wdata[16] (double data rate) clear, card_clk equals clk_m and ck_en is held high.
- R4: With a divide value of 0 and cfg_wdata[16] set, bypass is refused: card_clk is high for 1 master cycle and low for 1 master cycle.
- R5: The largest divide value gives the slowest clock: high and low halves of 2^DIV_W - 1 master cycles each.
- R6: A newly written divide value takes effect only at the end of a complete low half. A value written during a high half leaves that high half and the following low half at the old length.
- R7: ck_en is high for exactly the master cycles in which card_clk has just changed. In single-rate mode this covers rising changes only; in double-data-rate mode it covers both rising and falling changes.
- R8: bus_w reports the bus width: 0 for 1-bit when neither cfg_wdata[14] (4-bit) nor cfg_wdata[15] (8-bit) is set, 1 when only bit 14 is set, and 2 whenever bit 15 is set.
- R9: ddr_on, hwfc_on and hs_on echo cfg_wdata bits 16, 17 and 18. fbck_sel is high when cfg_wdata[21:20] equals 2 (the feedback clock source). These outputs update only on a cycle with cfg_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads cfg_wdata into the control register |
| cfg_wdata | input | 32 | Control word |
| card_clk | output | 1 | Divided or bypassed card clock |
| ck_en | output | 1 | One-cycle strobe after a card-clock edge |
| bus_w | output | 2 | Decoded bus width: 0 = 1-bit, 1 = 4-bit, 2 = 8-bit |
| ddr_on | output | 1 | Double-data-rate enable |
| hwfc_on | output | 1 | Hardware flow-control enable |
| hs_on | output | 1 | High-speed bus flag |
| fbck_sel | output | 1 | Feedback clock selected as sampling source |

## Verification
The bench measures the high and low run lengths of card_clk for random divide values in both rates, and for the extremes of zero and the maximum.

- A zero that is wrongly honoured as bypass in double-data-rate mode shows up as card_clk following clk_m instead of a divide-by-two.
- An off-by-one counter produces runs of N-1 or N+1 cycles.
- A divide value that is switched in immediately, rather than after the low half, cuts the high half or the low half in which it was written.
- A strobe on falling edges in single-rate mode, or a missing falling strobe in double-data-rate mode, is caught by comparing ck_en cycle by cycle against the edges of card_clk.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
   localparam int F_W4     = 14;
   localparam int F_W8     = 15;
   localparam int F_DDR    = 16;
   localparam int F_HWFC   = 17;
   localparam int F_HS     = 18;
   localparam int F_SRC_LO = 20;
   localparam logic [1:0] SRC_FBCK = 2'd2;
   typedef enum logic [1:0] {BW_1 = 2'd0, BW_4 = 2'd1, BW_8 = 2'd2} bus_w_e;
endpackage

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg
   import ckdiv_pkg::*;
#(
   parameter int DIV_W = 10
) (
   input  logic             clk_m,
   input  logic             rst_n,
   input  logic             we,
   input  logic [31:0]      wdata,
   output logic [DIV_W-1:0] div_val,
   output logic             ddr,
   output logic             hwfc,
   output logic             hs,
   output logic [1:0]       bus_w,
   output logic             fbck
);
   localparam logic [DIV_W-1:0] DIV_RST = '1;

   logic       w4_q, w8_q;
   logic [1:0] src_q;
   logic       unused_bits;

   assign unused_bits = ^{wdata[31:22], wdata[19], wdata[13:DIV_W]};

   always_ff @(posedge clk_m or negedge rst_n) begin
      if (!rst_n) begin
         div_val <= DIV_RST;
         w4_q    <= 1'b0;
         w8_q    <= 1'b0;
         ddr     <= 1'b0;
         hwfc    <= 1'b0;
         hs      <= 1'b0;
         src_q   <= 2'd0;
      end else if (we) begin
         div_val <= wdata[DIV_W-1:0];
         w4_q    <= wdata[F_W4];
         w8_q    <= wdata[F_W8];
         ddr     <= wdata[F_DDR];
         hwfc    <= wdata[F_HWFC];
         hs      <= wdata[F_HS];
         src_q   <= wdata[F_SRC_LO+1:F_SRC_LO];
      end
   end

   always_comb begin
      if (w8_q)      bus_w = BW_8;
      else if (w4_q) bus_w = BW_4;
      else           bus_w = BW_1;
   end

   assign fbck = (src_q == SRC_FBCK);

   // R9: status changes only after a write
   assert_cfg_hold_R9: assert property (@(posedge clk_m) disable iff (!rst_n)
      !$past(we) |-> $stable(bus_w) && $stable(ddr) && $stable(hs) && $stable(hwfc));
endmodule

// File: rtl/ckdiv_core.sv
module ckdiv_core #(
   parameter int DIV_W = 10
) (
   input  logic             clk_m,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_req,
   input  logic             ddr_req,
   output logic             card_clk,
   output logic             ck_en
);
   localparam logic [DIV_W-1:0] DIV_MAX = '1;
   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

   logic [DIV_W-1:0] act_div, nxt_div, cnt, nxt_cnt, lim, eff;
   logic             act_byp, nxt_byp, act_ddr, nxt_ddr;
   logic             ck_q, nxt_ck, end_half, upd, byp_new, en_d;

   // a zero in double-rate mode is promoted to one
   assign byp_new  = (div_req == '0) && !ddr_req;
   assign eff      = (div_req == '0) ? (ddr_req ? DIV_ONE : '0) : div_req;
   assign lim      = act_div - DIV_ONE;
   assign end_half = !act_byp && (cnt == lim);
   assign upd      = act_byp || (end_half && !ck_q);

   always_comb begin
      nxt_div = act_div;
      nxt_byp = act_byp;
      nxt_ddr = act_ddr;
      nxt_ck  = ck_q;
      nxt_cnt = cnt;
      if (!act_byp) begin
         if (end_half) begin
            nxt_cnt = '0;
            nxt_ck  = ~ck_q;
         end else begin
            nxt_cnt = cnt + DIV_ONE;
         end
      end
      if (upd) begin
         nxt_div = eff;
         nxt_byp = byp_new;
         nxt_ddr = ddr_req;
         if (byp_new) begin
            nxt_ck  = 1'b0;
            nxt_cnt = '0;
         end
      end
      en_d = nxt_byp | ((nxt_ck != ck_q) & (nxt_ck | act_ddr));
   end

   always_ff @(posedge clk_m or negedge rst_n) begin
      if (!rst_n) begin
         act_div <= DIV_MAX;
         act_byp <= 1'b0;
         act_ddr <= 1'b0;
         ck_q    <= 1'b0;
         cnt     <= '0;
         ck_en   <= 1'b0;
      end else begin
         act_div <= nxt_div;
         act_byp <= nxt_byp;
         act_ddr <= nxt_ddr;
         ck_q    <= nxt_ck;
         cnt     <= nxt_cnt;
         ck_en   <= en_d;
      end
   end

   assign card_clk = act_byp ? clk_m : ck_q;

   // R2: the half-period counter stays below the active divide value
   assert_cnt_range_R2: assert property (@(posedge clk_m) disable iff (!rst_n)
      !act_byp |-> cnt < act_div);
   // R6: the active divide value only changes after a low half
   assert_switch_low_R6: assert property (@(posedge clk_m) disable iff (!rst_n)
      !$stable(act_div) |-> !$past(ck_q));
   // R7: a strobe in divide mode follows a change of the card clock
   assert_strobe_edge_R7: assert property (@(posedge clk_m) disable iff (!rst_n)
      ck_en && !act_byp |-> ck_q != $past(ck_q));
   // R7: a falling-edge strobe needs double-rate mode
   assert_fall_ddr_R7: assert property (@(posedge clk_m) disable iff (!rst_n)
      ck_en && !act_byp && !ck_q |-> $past(act_ddr));
   // R4: bypass is never entered with double rate requested
   assert_no_ddr_byp_R4: assert property (@(posedge clk_m) disable iff (!rst_n)
      act_byp |-> !act_ddr);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
   parameter int DIV_W = 10
) (
   input  logic        clk_m,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic        card_clk,
   output logic        ck_en,
   output logic [1:0]  bus_w,
   output logic        ddr_on,
   output logic        hwfc_on,
   output logic        hs_on,
   output logic        fbck_sel
);
   generate
      if (DIV_W < 2 || DIV_W > 12) begin : g_bad_width
         $error("card_clk_div: DIV_W must lie in 2..12");
      end
   endgenerate

   logic [DIV_W-1:0] div_val;

   ckdiv_cfg #(.DIV_W(DIV_W)) u_cfg (
      .clk_m   (clk_m),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .div_val (div_val),
      .ddr     (ddr_on),
      .hwfc    (hwfc_on),
      .hs      (hs_on),
      .bus_w   (bus_w),
      .fbck    (fbck_sel)
   );

   ckdiv_core #(.DIV_W(DIV_W)) u_core (
      .clk_m    (clk_m),
      .rst_n    (rst_n),
      .div_req  (div_val),
      .ddr_req  (ddr_on),
      .card_clk (card_clk),
      .ck_en    (ck_en)
   );
endmodule

// File: tb/tb_card_clk_div.sv
module tb_card_clk_div;
   localparam int DW   = 10;
   localparam int DMAX = (1 << DW) - 1;

   logic        clk_m = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        card_clk, ck_en, ddr_on, hwfc_on, hs_on, fbck_sel;
   logic [1:0]  bus_w;
   int nchk = 0, nerr = 0, cyc = 0, prev_eff = DMAX;
   bit done = 0;

   always #2.5 clk_m = ~clk_m;

   card_clk_div #(.DIV_W(DW)) dut (
      .clk_m(clk_m), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .card_clk(card_clk), .ck_en(ck_en), .bus_w(bus_w), .ddr_on(ddr_on),
      .hwfc_on(hwfc_on), .hs_on(hs_on), .fbck_sel(fbck_sel));

   always @(posedge clk_m) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int eff_div(int d, bit ddr);
      if (d == 0) return ddr ? 1 : 0;
      return d;
   endfunction

   task automatic wr(int d, bit w4, bit w8, bit ddr, bit hwfc, bit hs, bit [1:0] src);
      @(negedge clk_m);
      cfg_we    = 1'b1;
      cfg_wdata = '0;
      cfg_wdata[DW-1:0] = d[DW-1:0];
      cfg_wdata[14] = w4; cfg_wdata[15] = w8; cfg_wdata[16] = ddr;
      cfg_wdata[17] = hwfc; cfg_wdata[18] = hs; cfg_wdata[21:20] = src;
      @(negedge clk_m);
      cfg_we = 1'b0;
   endtask

   task automatic sync_rise();
      while (card_clk !== 1'b0) @(negedge clk_m);
      while (card_clk !== 1'b1) @(negedge clk_m);
   endtask

   task automatic measure(int d, bit ddr, string req);
      int e = eff_div(d, ddr);
      int h = 0, l = 0;
      wr(d, 0, 0, ddr, 0, 0, 2'd0);
      repeat (2 * prev_eff + 2 * e + 4) @(negedge clk_m);
      prev_eff = e;
      sync_rise();
      while (card_clk === 1'b1) begin h++; @(negedge clk_m); end
      while (card_clk === 1'b0) begin l++; @(negedge clk_m); end
      chk(h == e, {req, " high half"}, h, e);
      chk(l == e, {req, " low half"}, l, e);
      for (int i = 0; i < 4 * e + 4; i++) begin
         logic p = card_clk;
         bit exp;
         @(negedge clk_m);
         exp = (card_clk != p) && (ddr || card_clk);
         chk(ck_en == exp, "R7 strobe", int'(ck_en), int'(exp));
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk_m);
      chk(card_clk == 0 && ck_en == 0, "R1 clock idle in reset", int'(card_clk), 0);
      rst_n = 1'b1;
      @(negedge clk_m);
      chk(card_clk == 0 && ck_en == 0, "R1 clock low after reset", int'(ck_en), 0);
      chk(bus_w == 0, "R1 width", int'(bus_w), 0);
      chk({ddr_on, hwfc_on, hs_on, fbck_sel} == 0, "R1 flags",
          int'({ddr_on, hwfc_on, hs_on, fbck_sel}), 0);
      begin
         int h = 0;
         sync_rise();
         while (card_clk === 1'b1) begin h++; @(negedge clk_m); end
         chk(h == DMAX, "R1 reset divider slowest", h, DMAX);
      end

      // R2 directed and random, both rates
      measure(1, 0, "R2 div1");
      measure(2, 1, "R2 ddr div2");
      for (int t = 0; t < 12; t++) begin
         int d = 1 + ($urandom % 40);
         bit dd = 1'($urandom % 2);
         measure(d, dd, "R2 random");
      end

      // R4: zero with double rate
      measure(0, 1, "R4 ddr zero");

      // R3: bypass
      wr(0, 0, 0, 0, 0, 0, 2'd0);
      repeat (2 * prev_eff + 6) @(negedge clk_m);
      prev_eff = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk_m);
         chk(card_clk == 0, "R3 bypass low phase", int'(card_clk), 0);
         chk(ck_en == 1, "R3 bypass strobe", int'(ck_en), 1);
         @(posedge clk_m); #1;
         chk(card_clk == 1, "R3 bypass high phase", int'(card_clk), 1);
      end
      measure(5, 0, "R2 leave bypass");

      // R5: slowest
      measure(DMAX, 0, "R5 max divider");
      measure(8, 0, "R6 setup");

      // R6: write in high half
      begin
         int h = 2, l = 0, h2 = 0, l2 = 0;
         sync_rise();
         wr(3, 0, 0, 0, 0, 0, 2'd0);
         while (card_clk === 1'b1) begin h++; @(negedge clk_m); end
         while (card_clk === 1'b0) begin l++; @(negedge clk_m); end
         while (card_clk === 1'b1) begin h2++; @(negedge clk_m); end
         while (card_clk === 1'b0) begin l2++; @(negedge clk_m); end
         chk(h == 8, "R6 current high keeps old", h, 8);
         chk(l == 8, "R6 following low keeps old", l, 8);
         chk(h2 == 3, "R6 new high", h2, 3);
         chk(l2 == 3, "R6 new low", l2, 3);
         prev_eff = 3;
      end

      // R8: bus width decode
      wr(3, 0, 0, 0, 0, 0, 2'd0); chk(bus_w == 0, "R8 1-bit", int'(bus_w), 0);
      wr(3, 1, 0, 0, 0, 0, 2'd0); chk(bus_w == 1, "R8 4-bit", int'(bus_w), 1);
      wr(3, 0, 1, 0, 0, 0, 2'd0); chk(bus_w == 2, "R8 8-bit", int'(bus_w), 2);
      wr(3, 1, 1, 0, 0, 0, 2'd0); chk(bus_w == 2, "R8 both flags", int'(bus_w), 2);

      // R9: flag echo and hold without write
      wr(3, 0, 0, 1, 1, 1, 2'd2);
      chk({ddr_on, hwfc_on, hs_on, fbck_sel} == 4'b1111, "R9 flags set",
          int'({ddr_on, hwfc_on, hs_on, fbck_sel}), 15);
      cfg_wdata = '0;
      repeat (3) @(negedge clk_m);
      chk({ddr_on, hwfc_on, hs_on, fbck_sel} == 4'b1111, "R9 hold without write",
          int'({ddr_on, hwfc_on, hs_on, fbck_sel}), 15);
      wr(3, 0, 0, 0, 1, 0, 2'd1);
      chk({ddr_on, hwfc_on, hs_on, fbck_sel} == 4'b0100, "R9 other source",
          int'({ddr_on, hwfc_on, hs_on, fbck_sel}), 4);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule